// File: doc/BRIEF.md
# Out-of-Order Read Completion Reorder Buffer

This block sits between a read requester and a packet link on which read completions may come back in any order. Each read is issued through the issue port with its expected byte count. The block assigns the read a channel and returns the channel number, which the requester uses as the tag of the outgoing request. Channels are handed out in a rotating order. Because they are also released in that order, the issue-order queue reduces to a head pointer and a tail pointer over the channel ring.

Completions arrive as packets of 64-bit beats. The first beat is a header that carries the tag. The block drops that beat and appends the payload beats that follow it to the channel the tag selects. One read may be answered by several completions, and their payloads are concatenated in arrival order. The output port drains only the channel at the head of the ring. It can stream words as soon as they land. It marks the final word of each read and then frees that channel for a new issue. A completion whose tag names no allocated channel is discarded and flagged.

Top module: `cpl_reorder`

## Requirements
- R1: After reset, iss_ready is 1, iss_tag is 0, rd_valid is 0 and cpl_drop is 0.
- R2: Accepted issues (iss_valid and iss_ready both 1 at a clock edge) are assigned channels 0, 1, ..., NUM_CH-1 and then 0 again, in rotation. iss_tag shows the channel the next issue will receive. The requester places that number in header bits [7:0] of the matching completions.
- R3: A completion packet begins with a header beat, marked by cpl_sop=1, which is never stored or output. Only the beats after it, up to and including the beat with cpl_eop=1, are payload.
- R4: Payload beats are appended to their channel in arrival order. Several completions for the same tag continue filling that channel where the previous one stopped.
- R5: Output words leave strictly in issue order. Data already held for a later read is withheld (rd_valid=0) while the head read has no word available.
- R6: A payload word accepted for the head channel at a clock edge is presented on rd_data with rd_valid=1 from that edge onward. The block does not wait for the whole read to arrive.
- R7: Each read delivers ceil(bytes/8) words. rd_last is 1 exactly on the final one. Once that word is accepted, the head advances to the next issued channel.
- R8: While all NUM_CH channels are allocated, iss_ready is 0. It returns to 1 right after the edge at which the head read's last word is accepted.
- R9: A header whose tag value in bits [7:0] is not below NUM_CH, or that names an unallocated channel, causes its whole packet to be discarded. cpl_drop is 1 for the one cycle after the edge that accepted that header, and no word of the packet is ever output.
- R10: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data and rd_last hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A read is being issued |
| iss_ready | output | 1 | A free channel is available for the next issue |
| iss_bytes | input | BYTES_W | Expected byte count of the read, 1 to CH_WORDS*8 |
| iss_tag | output | CH_W | Channel (tag) the next accepted issue receives |
| cpl_valid | input | 1 | Completion beat present |
| cpl_sop | input | 1 | Beat is a header; bits [7:0] carry the tag |
| cpl_eop | input | 1 | Beat is the last of its packet |
| cpl_data | input | DATA_W | Header or payload beat |
| cpl_drop | output | 1 | One-cycle flag that a packet was discarded for a bad tag |
| rd_valid | output | 1 | In-order output word available |
| rd_ready | input | 1 | Consumer takes the output word |
| rd_data | output | DATA_W | In-order output word |
| rd_last | output | 1 | Final word of the current read |

## Verification
The directed scenarios send completions in the opposite order to issue. They also split one read across two completions and stream a read word by word. Reversed arrival separates a correct head-only drain from one that outputs whichever channel filled first. Split arrival shows whether a second packet appends to its channel or overwrites it. A tag beyond the channel count and a tag for a free channel both exercise the drop path. Filling every channel and then holding back the consumer checks that issue is blocked, that it is released only after the head read's last word, and that the output holds steady under back-pressure.

// File: rtl/cpl_reorder_pkg.sv
package cpl_reorder_pkg;
   localparam int TAG_FIELD_LSB = 0;
   localparam int TAG_FIELD_W   = 8;

   function automatic logic [TAG_FIELD_W-1:0] hdr_tag(input logic [63:0] beat);
      return beat[TAG_FIELD_LSB +: TAG_FIELD_W];
   endfunction
endpackage

// File: rtl/cpl_reorder_alloc.sv
module cpl_reorder_alloc #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_fire,
   input  logic              rel_fire,
   output logic [NUM_CH-1:0] busy,
   output logic [CH_W-1:0]   head,
   output logic [CH_W-1:0]   tail
);
   function automatic logic [CH_W-1:0] bump(input logic [CH_W-1:0] p);
      return (p == CH_W'(NUM_CH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
      end else begin
         if (iss_fire) tail <= bump(tail);
         if (rel_fire) head <= bump(head);
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_busy
      always_ff @(posedge clk) begin
         if (!rst_n)
            busy[i] <= 1'b0;
         else if (iss_fire && tail == CH_W'(i))
            busy[i] <= 1'b1;
         else if (rel_fire && head == CH_W'(i))
            busy[i] <= 1'b0;
      end
   end

   AST_RELEASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rel_fire |-> busy[head]); // R7
endmodule

// File: rtl/cpl_reorder_ingress.sv
module cpl_reorder_ingress
   import cpl_reorder_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CH_W   = $clog2(NUM_CH),
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpl_valid,
   input  logic              cpl_sop,
   input  logic              cpl_eop,
   input  logic [DATA_W-1:0] cpl_data,
   input  logic [NUM_CH-1:0] busy,
   output logic              wr_en,
   output logic [CH_W-1:0]   wr_ch,
   output logic              cpl_drop
);
   logic [TAG_FIELD_W-1:0] tag;
   logic                   hdr_beat;
   logic                   tag_ok;
   logic                   pkt_on;
   logic                   pkt_ok;
   logic [CH_W-1:0]        pkt_ch;

   assign hdr_beat = cpl_valid && cpl_sop;
   assign tag      = hdr_tag(64'(cpl_data));
   assign tag_ok   = (int'(tag) < NUM_CH) && busy[tag[CH_W-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_on   <= 1'b0;
         pkt_ok   <= 1'b0;
         pkt_ch   <= '0;
         cpl_drop <= 1'b0;
      end else begin
         cpl_drop <= hdr_beat && !tag_ok;
         if (hdr_beat) begin
            pkt_on <= !cpl_eop;
            pkt_ok <= tag_ok;
            pkt_ch <= tag[CH_W-1:0];
         end else if (cpl_valid && cpl_eop) begin
            pkt_on <= 1'b0;
         end
      end
   end

   assign wr_en = cpl_valid && !cpl_sop && pkt_on && pkt_ok;
   assign wr_ch = pkt_ch;

   AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_drop |-> !wr_en); // R9
endmodule

// File: rtl/cpl_reorder_store.sv
module cpl_reorder_store #(
   parameter int NUM_CH   = 4,
   parameter int CH_WORDS = 8,
   parameter int DATA_W   = 64,
   parameter int CH_W     = $clog2(NUM_CH),
   parameter int CNT_W    = $clog2(CH_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr,
   input  logic [CH_W-1:0]   rd_ch,
   input  logic [CNT_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word,
   output logic [CNT_W-1:0]  rd_fill
);
   localparam int DEPTH = NUM_CH * CH_WORDS;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]  cnt [NUM_CH];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt[i] <= '0;
         else if (clr && rd_ch == CH_W'(i))
            cnt[i] <= '0;
         else if (wr_en && wr_ch == CH_W'(i))
            cnt[i] <= cnt[i] + 1'b1;
      end
   end

   int wr_addr;
   int rd_addr;
   assign wr_addr = int'(wr_ch) * CH_WORDS + int'(cnt[wr_ch]);
   assign rd_addr = int'(rd_ch) * CH_WORDS + int'(rd_idx);

   always_ff @(posedge clk) begin
      if (wr_en && wr_addr < DEPTH) mem[wr_addr] <= wr_data;
   end

   assign rd_word = (rd_addr < DEPTH) ? mem[rd_addr] : '0;
   assign rd_fill = cnt[rd_ch];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> int'(cnt[wr_ch]) < CH_WORDS); // R4
endmodule

// File: rtl/cpl_reorder.sv
module cpl_reorder #(
   parameter int NUM_CH   = 4,
   parameter int CH_WORDS = 8,
   parameter int DATA_W   = 64,
   localparam int CH_W    = $clog2(NUM_CH),
   localparam int CNT_W   = $clog2(CH_WORDS + 1),
   localparam int BPW     = DATA_W / 8,
   localparam int BYTES_W = $clog2(CH_WORDS * BPW + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               iss_valid,
   output logic               iss_ready,
   input  logic [BYTES_W-1:0] iss_bytes,
   output logic [CH_W-1:0]    iss_tag,
   input  logic               cpl_valid,
   input  logic               cpl_sop,
   input  logic               cpl_eop,
   input  logic [DATA_W-1:0]  cpl_data,
   output logic               cpl_drop,
   output logic               rd_valid,
   input  logic               rd_ready,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rd_last
);
   if (NUM_CH < 2 || NUM_CH > 256) begin : g_bad_num_ch
      $error("NUM_CH must lie in 2..256");
   end
   if (CH_WORDS < 1) begin : g_bad_depth
      $error("CH_WORDS must be at least 1");
   end
   if (DATA_W != 64) begin : g_bad_width
      $error("DATA_W must be 64");
   end

   logic [NUM_CH-1:0] busy;
   logic [CH_W-1:0]   head, tail, wr_ch;
   logic              wr_en, iss_fire, rd_fire, rel_fire;
   logic [CNT_W-1:0]  rd_cnt, head_fill;
   logic [CNT_W-1:0]  need [NUM_CH];
   logic [BYTES_W:0]  bytes_rnd;

   assign iss_ready = !busy[tail];
   assign iss_tag   = tail;
   assign iss_fire  = iss_valid && iss_ready;
   assign bytes_rnd = {1'b0, iss_bytes} + (BYTES_W+1)'(BPW - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) need[i] <= '0;
      end else if (iss_fire) begin
         need[tail] <= CNT_W'(bytes_rnd / (BYTES_W+1)'(BPW));
      end
   end

   cpl_reorder_alloc #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_alloc (
      .clk, .rst_n, .iss_fire, .rel_fire, .busy, .head, .tail
   );

   cpl_reorder_ingress #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_ingress (
      .clk, .rst_n, .cpl_valid, .cpl_sop, .cpl_eop, .cpl_data, .busy,
      .wr_en, .wr_ch, .cpl_drop
   );

   cpl_reorder_store #(.NUM_CH(NUM_CH), .CH_WORDS(CH_WORDS), .DATA_W(DATA_W),
                       .CH_W(CH_W), .CNT_W(CNT_W)) u_store (
      .clk, .rst_n, .wr_en, .wr_ch, .wr_data(cpl_data), .clr(rel_fire),
      .rd_ch(head), .rd_idx(rd_cnt), .rd_word(rd_data), .rd_fill(head_fill)
   );

   assign rd_valid = busy[head] && (rd_cnt < head_fill);
   assign rd_last  = (rd_cnt == need[head] - 1'b1);
   assign rd_fire  = rd_valid && rd_ready;
   assign rel_fire = rd_fire && rd_last;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_cnt <= '0;
      else if (rel_fire)
         rd_cnt <= '0;
      else if (rd_fire)
         rd_cnt <= rd_cnt + 1'b1;
   end

   AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_last)); // R10
endmodule

// File: tb/cpl_reorder_test.sv
module cpl_reorder_test;
   localparam int NUM_CH = 4;
   localparam int CH_WORDS = 8;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        iss_valid = 0;
   logic        iss_ready;
   logic [6:0]  iss_bytes = '0;
   logic [1:0]  iss_tag;
   logic        cpl_valid = 0, cpl_sop = 0, cpl_eop = 0;
   logic [63:0] cpl_data = '0;
   logic        cpl_drop;
   logic        rd_valid;
   logic        rd_ready = 0;
   logic [63:0] rd_data;
   logic        rd_last;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   cpl_reorder #(.NUM_CH(NUM_CH), .CH_WORDS(CH_WORDS), .DATA_W(64)) uut (
      .clk, .rst_n, .iss_valid, .iss_ready, .iss_bytes, .iss_tag,
      .cpl_valid, .cpl_sop, .cpl_eop, .cpl_data, .cpl_drop,
      .rd_valid, .rd_ready, .rd_data, .rd_last
   );

   task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic issue(input int bytes, input int exp_tag);
      @(negedge clk);
      check("R2 issue tag", 65'(iss_tag), 65'(exp_tag));
      check("R8 issue ready", 65'(iss_ready), 65'd1);
      iss_valid = 1;
      iss_bytes = 7'(bytes);
      @(negedge clk);
      iss_valid = 0;
   endtask

   task automatic send_cpl(input int tag, input int n, input logic [63:0] base, output logic drop);
      @(negedge clk);
      cpl_valid = 1; cpl_sop = 1; cpl_eop = (n == 0);
      cpl_data = {56'hF00D_CAFE_0000_00, 8'(tag)};
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == 0) drop = cpl_drop;
         cpl_sop = 0; cpl_eop = (i == n - 1);
         cpl_data = base + 64'(i);
      end
      @(negedge clk);
      if (n == 0) drop = cpl_drop;
      cpl_valid = 0; cpl_sop = 0; cpl_eop = 0;
   endtask

   task automatic read_words(input string req, input int n, input logic [63:0] base, input logic fin);
      @(negedge clk);
      rd_ready = 1;
      for (int i = 0; i < n; i++) begin
         for (int w = 0; w < 100 && !rd_valid; w++) @(negedge clk);
         check(req, {rd_last, rd_data}, {fin && (i == n - 1), base + 64'(i)});
         @(negedge clk);
      end
      rd_ready = 0;
   endtask

   task automatic t_reset;
      check("R1 iss_ready", 65'(iss_ready), 65'd1);
      check("R1 iss_tag", 65'(iss_tag), 65'd0);
      check("R1 rd_valid", 65'(rd_valid), 65'd0);
      check("R1 cpl_drop", 65'(cpl_drop), 65'd0);
   endtask

   task automatic t_reverse_order;
      logic d;
      issue(16, 0);
      issue(24, 1);
      send_cpl(1, 3, 64'h1100, d);
      check("R9 good tag not dropped", 65'(d), 65'd0);
      check("R5 later read withheld", 65'(rd_valid), 65'd0);
      send_cpl(0, 2, 64'h0A00, d);
      read_words("R5 R3 first read", 2, 64'h0A00, 1);
      read_words("R5 R7 second read", 3, 64'h1100, 1);
   endtask

   task automatic t_split;
      logic d;
      issue(20, 2);
      send_cpl(2, 1, 64'h2200, d);
      check("R6 stream valid", 65'(rd_valid), 65'd1);
      check("R6 stream data", 65'(rd_data), 65'h2200);
      read_words("R7 not last yet", 1, 64'h2200, 0);
      check("R6 waits for more", 65'(rd_valid), 65'd0);
      send_cpl(2, 2, 64'h2201, d);
      read_words("R4 appended words", 2, 64'h2201, 1);
   endtask

   task automatic t_drop;
      logic d;
      send_cpl(5, 2, 64'h5500, d);
      check("R9 out of range flagged", 65'(d), 65'd1);
      check("R9 drop is one pulse", 65'(cpl_drop), 65'd0);
      send_cpl(3, 1, 64'h3300, d);
      check("R9 free channel flagged", 65'(d), 65'd1);
      repeat (2) @(negedge clk);
      check("R9 nothing output", 65'(rd_valid), 65'd0);
   endtask

   task automatic t_full;
      logic d;
      logic [63:0] held;
      issue(8, 3);
      issue(8, 0);
      issue(8, 1);
      issue(8, 2);
      check("R8 full blocks issue", 65'(iss_ready), 65'd0);
      send_cpl(2, 1, 64'h4200, d);
      send_cpl(1, 1, 64'h4100, d);
      send_cpl(0, 1, 64'h4000, d);
      check("R5 head missing", 65'(rd_valid), 65'd0);
      send_cpl(3, 1, 64'h4300, d);
      held = rd_data;
      repeat (3) @(negedge clk);
      check("R10 valid held", 65'(rd_valid), 65'd1);
      check("R10 data held", {rd_last, rd_data}, {1'b1, held});
      check("R8 still blocked", 65'(iss_ready), 65'd0);
      read_words("R5 head read", 1, 64'h4300, 1);
      check("R8 reopened after head", 65'(iss_ready), 65'd1);
      read_words("R5 drain 0", 1, 64'h4000, 1);
      read_words("R5 drain 1", 1, 64'h4100, 1);
      read_words("R5 drain 2", 1, 64'h4200, 1);
      check("R7 all drained", 65'(rd_valid), 65'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_reverse_order();
      t_split();
      t_drop();
      t_full();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule